// File: doc/BRIEF.md
# MDIO Management Slave with Emulated PHY Registers

This block answers the two-wire Ethernet management interface (clause-22 framing) on behalf of one emulated PHY. It oversamples the management clock and data line with the system clock. It recognises a preamble, then decodes the start bits, the opcode, the PHY and register addresses and the turnaround, and then moves 16 data bits. Reads put data on a split bidirectional pin (`mdio_out` plus `mdio_oe`), which the pad ring merges into one open line. Writes go into a 32-entry register file.

Three registers are not stored values when read. The status register reports fixed capabilities plus the live link input. The link-partner register and the diagnostic register are computed from the locally written advertisement register, so negotiation always appears to settle on the best advertised mode. The diagnostic duplex result is also exported as a port for the local MAC.

Top module: `mdio_phy_slave`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 reads 0x01E1, every other stored register reads 0, and `mdio_oe` is low.
- R2: A frame is recognised only when at least PRE_BITS (32) consecutive 1 bits are sampled and then a 0 bit is sampled. With a shorter run of ones the frame is ignored. A longer run is accepted.
- R3: After that 0, the slave takes one more start bit, a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits, each field MSB first. The slave then waits for a new preamble.
- R4: Opcode 2'b10 is a read and 2'b01 is a write. Opcodes 2'b00 and 2'b11 write nothing and drive nothing.
- R5: Only frames whose PHY address equals PHY_ADDR (default 1) are answered. Other addresses neither write nor raise `mdio_oe`.
- R6: In an answered read, `mdio_oe` is low during the first turnaround bit. It is high with `mdio_out` = 0 during the second turnaround bit, and stays high through all 16 data bits, which are driven bit 15 first. It is low again in the bit after the frame.
- R7: A write commits the 16 shifted bits after the last data bit, and a later read of any stored register (every index except 1, 5 and 18) returns that value.
- R8: Register 1 reads 0x7828 with bit 2 equal to `link_up`.
- R9: Register 5 reads 0x4000 ORed with bits 8:5 of register 4.
- R10: Register 18 reads bit 10 = reg4[7] | reg4[8] and bit 11 = reg4[8] | reg4[6], with every other bit 0. `full_duplex` equals that bit 11 at all times.
- R11: `mdio_out` and `mdio_oe` change only after a falling MDC edge, and `mdio_out` is 0 whenever `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the management lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_in | input | 1 | Management data as seen at the pad |
| link_up | input | 1 | Link indication reported in status bit 2 |
| mdio_out | output | 1 | Data driven toward the pad during reads |
| mdio_oe | output | 1 | Pad output enable for `mdio_out` |
| full_duplex | output | 1 | Derived duplex result (register 18 bit 11) |

## Verification
The bench uses the defaults: PHY address 1, two synchroniser stages and a 32-bit preamble, with MDC running at one eighth of the system clock. At this size it can read every register index straight after reset and write back all 29 stored indices. It walks all 16 combinations of the advertised-mode bits 8:5 through the derived registers and the duplex port, and sends reads to each of the 31 foreign PHY addresses. Short and long preambles and both unused opcodes are also exercised, and the drive window is checked bit by bit on each read.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

   typedef enum logic [2:0] {
      ST_PRE,
      ST_SOF,
      ST_OPC,
      ST_PAD,
      ST_RAD,
      ST_TA,
      ST_DAT
   } mdio_st_e;

   localparam int IDX_CTRL    = 0;
   localparam int IDX_STATUS  = 1;
   localparam int IDX_ID_HI   = 2;
   localparam int IDX_ID_LO   = 3;
   localparam int IDX_ADV     = 4;
   localparam int IDX_PARTNER = 5;
   localparam int IDX_DIAG    = 18;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;

   function automatic logic [15:0] reg_reset(input int idx);
      case (idx)
         IDX_CTRL:  return 16'h3100;
         IDX_ID_HI: return 16'h0300;
         IDX_ID_LO: return 16'hE400;
         IDX_ADV:   return 16'h01E1;
         default:   return 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdio_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
   import mdio_slv_pkg::*;
#(
   parameter int PHY_ADDR = 1,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int PRE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc_s,
   input  logic              mdio_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              mdio_out,
   output logic              mdio_oe
);
   localparam int CNT_W  = $clog2(DATA_W);
   localparam int PCNT_W = $clog2(PRE_BITS + 1);
   localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);
   localparam logic [PCNT_W-1:0] PRE_FULL  = PCNT_W'(PRE_BITS);
   localparam logic [ADDR_W-1:0] MY_ADDR   = ADDR_W'(PHY_ADDR);

   generate
      if (DATA_W <= ADDR_W) begin : g_bad_width
         $error("data field must be wider than the address field");
      end
      if (PHY_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("PHY_ADDR does not fit the address field");
      end
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("PRE_BITS must be positive");
      end
   endgenerate

   logic              mdc_q;
   logic              rise, fall;
   mdio_st_e          st;
   logic [CNT_W-1:0]  bcnt;
   logic [PCNT_W-1:0] pre_cnt;
   logic [1:0]        opc;
   logic [ADDR_W-1:0] pad, rad;
   logic [DATA_W-1:0] rd_q, sh;
   logic              rd_act, wr_act;

   assign rise     = mdc_s & ~mdc_q;
   assign fall     = ~mdc_s & mdc_q;
   assign reg_addr = rad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdc_q <= 1'b0;
      else        mdc_q <= mdc_s;
   end

   // receive side: every field advances on a rising MDC edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_PRE;
         bcnt    <= '0;
         pre_cnt <= '0;
         opc     <= '0;
         pad     <= '0;
         rad     <= '0;
         rd_q    <= '0;
         sh      <= '0;
         rd_act  <= 1'b0;
         wr_act  <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (rise) begin
            case (st)
               ST_PRE: begin
                  if (mdio_s) begin
                     if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
                  end else begin
                     pre_cnt <= '0;
                     if (pre_cnt == PRE_FULL) st <= ST_SOF;
                  end
               end
               ST_SOF: begin
                  st   <= ST_OPC;
                  bcnt <= '0;
               end
               ST_OPC: begin
                  opc <= {opc[0], mdio_s};
                  if (bcnt == CNT_W'(1)) begin
                     st   <= ST_PAD;
                     bcnt <= '0;
                  end else bcnt <= bcnt + 1'b1;
               end
               ST_PAD: begin
                  pad <= {pad[ADDR_W-2:0], mdio_s};
                  if (bcnt == ADDR_LAST) begin
                     st   <= ST_RAD;
                     bcnt <= '0;
                  end else bcnt <= bcnt + 1'b1;
               end
               ST_RAD: begin
                  rad <= {rad[ADDR_W-2:0], mdio_s};
                  if (bcnt == ADDR_LAST) begin
                     st   <= ST_TA;
                     bcnt <= '0;
                  end else bcnt <= bcnt + 1'b1;
               end
               ST_TA: begin
                  if (bcnt == '0) begin
                     rd_q   <= rd_data;
                     rd_act <= (pad == MY_ADDR) && (opc == OPC_READ);
                     wr_act <= (pad == MY_ADDR) && (opc == OPC_WRITE);
                     bcnt   <= bcnt + 1'b1;
                  end else begin
                     st   <= ST_DAT;
                     bcnt <= '0;
                  end
               end
               ST_DAT: begin
                  sh <= {sh[DATA_W-2:0], mdio_s};
                  if (bcnt == DATA_LAST) begin
                     wr_en   <= wr_act;
                     wr_data <= {sh[DATA_W-2:0], mdio_s};
                     rd_act  <= 1'b0;
                     wr_act  <= 1'b0;
                     st      <= ST_PRE;
                     pre_cnt <= '0;
                     bcnt    <= '0;
                  end else bcnt <= bcnt + 1'b1;
               end
               default: st <= ST_PRE;
            endcase
         end
      end
   end

   // drive side: pad outputs move only after a falling MDC edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdio_oe  <= 1'b0;
         mdio_out <= 1'b0;
      end else if (fall) begin
         mdio_oe  <= rd_act && ((st == ST_TA && bcnt == CNT_W'(1)) || st == ST_DAT);
         mdio_out <= rd_act && (st == ST_DAT) && rd_q[DATA_LAST - bcnt];
      end
   end

   a_r2_preamble_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PRE && pre_cnt != PRE_FULL) |=> (st == ST_PRE));

   a_r5_drive_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> (pad == MY_ADDR && opc == OPC_READ));

   a_r11_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> ($stable(mdio_out) && $stable(mdio_oe)));

   a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mdio_oe |-> !mdio_out);

   a_r7_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   a_r3_commit_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (st == ST_PRE));
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
   import mdio_slv_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              full_duplex
);
   localparam int REG_COUNT = 1 << ADDR_W;

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("register layout assumes 16-bit registers");
      end
      if (REG_COUNT <= IDX_DIAG) begin : g_bad_count
         $error("address field too narrow for the diagnostic register");
      end
   endgenerate

   logic [DATA_W-1:0] mem [REG_COUNT];
   logic [DATA_W-1:0] adv;
   logic              adv_100;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) mem[i] <= reg_reset(i);
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign adv         = mem[IDX_ADV];
   assign adv_100     = adv[7] | adv[8];
   assign full_duplex = adv[8] | adv[6];

   always_comb begin
      case (rd_addr)
         ADDR_W'(IDX_STATUS):  rd_data = 16'h7828 | {13'b0, link_up, 2'b00};
         ADDR_W'(IDX_PARTNER): rd_data = 16'h4000 | (adv & 16'h01E0);
         ADDR_W'(IDX_DIAG):    rd_data = {4'b0000, full_duplex, adv_100, 10'b0};
         default:              rd_data = mem[rd_addr];
      endcase
   end

   a_r7_adv_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(IDX_ADV)) |=> (adv == $past(wr_data)));

   a_r7_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(adv));
endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave #(
   parameter int PHY_ADDR    = 1,
   parameter int SYNC_STAGES = 2,
   parameter int PRE_BITS    = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_in,
   input  logic link_up,
   output logic mdio_out,
   output logic mdio_oe,
   output logic full_duplex
);
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;

   logic              mdc_s, mdio_s;
   logic [ADDR_W-1:0] reg_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;

   mdio_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mdc, mdio_in}),
      .q     ({mdc_s, mdio_s})
   );

   mdio_frame_fsm #(
      .PHY_ADDR (PHY_ADDR),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PRE_BITS (PRE_BITS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc_s    (mdc_s),
      .mdio_s   (mdio_s),
      .rd_data  (rd_data),
      .reg_addr (reg_addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .mdio_out (mdio_out),
      .mdio_oe  (mdio_oe)
   );

   mdio_phy_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_up     (link_up),
      .rd_addr     (reg_addr),
      .wr_en       (wr_en),
      .wr_addr     (reg_addr),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .full_duplex (full_duplex)
   );
endmodule

// File: tb/tb_mdio_phy_slave.sv
module tb_mdio_phy_slave;
   localparam int HP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic mdio_in = 1'b1;
   logic link_up = 1'b0;
   wire  mdio_out, mdio_oe, full_duplex;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [15:0] f_rd;
   int          f_oe_cnt, f_stray;
   logic        f_ta1_oe, f_ta2_out, f_tail_oe;

   always #4 clk = ~clk;

   mdio_phy_slave dut (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
      .link_up(link_up), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
      .full_duplex(full_duplex)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bit_io(input logic b, output logic o, output logic e);
      @(negedge clk);
      mdc = 1'b0;
      mdio_in = b;
      repeat (HP) @(negedge clk);
      mdc = 1'b1;
      repeat (HP - 1) @(negedge clk);
      o = mdio_out;
      e = mdio_oe;
      if (!e && o) f_stray++;
   endtask

   task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                        input logic [4:0] ra, input logic [15:0] wd);
      logic o, e;
      f_oe_cnt = 0;
      f_stray = 0;
      f_rd = '0;
      for (int i = 0; i < pre; i++) bit_io(1'b1, o, e);
      bit_io(1'b0, o, e);
      bit_io(1'b1, o, e);
      for (int i = 1; i >= 0; i--) bit_io(op[i], o, e);
      for (int i = 4; i >= 0; i--) bit_io(pa[i], o, e);
      for (int i = 4; i >= 0; i--) bit_io(ra[i], o, e);
      bit_io(1'b1, o, e);
      f_ta1_oe = e;
      bit_io((op == 2'b01) ? 1'b0 : 1'b1, o, e);
      f_ta2_out = o;
      if (e) f_oe_cnt++;
      for (int i = 15; i >= 0; i--) begin
         bit_io((op == 2'b01) ? wd[i] : 1'b1, o, e);
         f_rd[i] = o;
         if (e) f_oe_cnt++;
      end
      bit_io(1'b1, o, e);
      f_tail_oe = e;
   endtask

   task automatic wr(input logic [4:0] ra, input logic [15:0] wd);
      frame(32, 2'b01, 5'd1, ra, wd);
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] ra, input logic [15:0] exp);
      frame(32, 2'b10, 5'd1, ra, 16'hFFFF);
      chk(tag, {16'h0, f_rd}, {16'h0, exp});
      chk("R6 drive window", {24'h0, f_ta1_oe, f_ta2_out, f_tail_oe, f_oe_cnt[4:0]},
          {24'h0, 3'b000, 5'd17});
      chk("R11 out low while released", f_stray, 0);
   endtask

   task automatic quiet_chk(input string tag);
      chk(tag, f_oe_cnt, 0);
      chk("R11 out low while released", f_stray, 0);
   endtask

   function automatic logic [15:0] pat(input int i);
      return 16'(i * 16'h0F1D + 16'h5A5A);
   endfunction

   function automatic logic [15:0] reset_exp(input int i);
      case (i)
         0:  return 16'h3100;
         1:  return 16'h7828;
         2:  return 16'h0300;
         3:  return 16'hE400;
         4:  return 16'h01E1;
         5:  return 16'h41E0;
         18: return 16'h0C00;
         default: return 16'h0000;
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v0;
      logic [15:0] adv;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 oe low after reset", mdio_oe, 0);
      chk("R10 duplex from reset adv", full_duplex, 1);
      for (int i = 0; i < 32; i++) begin
         string tg;
         tg = (i == 1) ? "R8 status" : (i == 5) ? "R9 partner" :
              (i == 18) ? "R10 diag" : "R1 reset value";
         rd_chk(tg, 5'(i), reset_exp(i));
      end

      // R8 link bit
      link_up = 1'b1;
      rd_chk("R8 status link up", 5'd1, 16'h782C);
      link_up = 1'b0;
      rd_chk("R8 status link down", 5'd1, 16'h7828);

      // R9 R10 all advertised-mode combinations
      for (int k = 0; k < 16; k++) begin
         logic [3:0] m;
         m = 4'(k);
         adv = 16'hA01F | {7'b0, m, 5'b0};
         wr(5'd4, adv);
         chk("R10 full_duplex port", full_duplex, m[3] | m[1]);
         rd_chk("R7 adv readback", 5'd4, adv);
         rd_chk("R9 partner", 5'd5, 16'h4000 | {7'b0, m, 5'b0});
         rd_chk("R10 diag", 5'd18,
                {4'b0, m[3] | m[1], m[3] | m[2], 10'b0});
      end

      // R3 R7 write and read back every stored register
      for (int i = 0; i < 32; i++)
         if (i != 1 && i != 5 && i != 18) wr(5'(i), pat(i));
      for (int i = 0; i < 32; i++)
         if (i != 1 && i != 5 && i != 18) rd_chk("R3 R7 readback", 5'(i), pat(i));
      v0 = pat(0);

      // R5 foreign addresses
      for (int pa = 0; pa < 32; pa++) begin
         if (pa != 1) begin
            frame(32, 2'b10, 5'(pa), 5'd0, 16'hFFFF);
            quiet_chk("R5 foreign read no drive");
         end
      end
      frame(32, 2'b01, 5'd0, 5'd0, 16'h1111);
      frame(32, 2'b01, 5'd2, 5'd0, 16'h2222);
      frame(32, 2'b01, 5'd31, 5'd0, 16'h3333);
      rd_chk("R5 foreign write ignored", 5'd0, v0);

      // R4 unused opcodes
      frame(32, 2'b00, 5'd1, 5'd0, 16'h0BAD);
      quiet_chk("R4 opcode 00 no drive");
      frame(32, 2'b11, 5'd1, 5'd0, 16'h0BAD);
      quiet_chk("R4 opcode 11 no drive");
      rd_chk("R4 unused opcodes write nothing", 5'd0, v0);

      // R2 preamble length
      begin
         logic o, e;
         bit_io(1'b0, o, e);
      end
      frame(31, 2'b01, 5'd1, 5'd0, 16'h0000);
      quiet_chk("R2 short preamble no drive");
      rd_chk("R2 short preamble ignored", 5'd0, v0);
      frame(40, 2'b01, 5'd1, 5'd0, 16'h7E57);
      rd_chk("R2 long preamble accepted", 5'd0, 16'h7E57);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule